// File: doc/BRIEF.md
# Store Granularity Policy and Write-Ordering Guard

This block decides, for each store that reaches a persistent-memory controller, what must happen before that store is allowed to land. Every tracked entry is handled either at line granularity, with direct writes to persistent memory, or at page granularity, with a volatile shadow page. The guard reads the handling mode of the target entry, the epoch in which the target's newest version was written, and whether the previous epoch has finished persisting. From these it issues exactly one action: proceed, copy the older page first, park the line in a temporary buffer slot, or stall.

The guard also owns the per-entry mode table. When the epoch-end strobe arrives, it compares each entry's store count for the epoch that just closed against two thresholds. A busy line-mode entry is promoted to page mode. A quiet page-mode entry is demoted to line mode. Each change is reported for one cycle so that the surrounding controller can allocate or release the page frame. The store counters, the thresholds and the persistence status all come from outside. The data copies themselves are done elsewhere.

Stores enter on a valid/ready channel, and actions leave on a valid/ready channel. A store is taken on any edge where `st_valid` and `st_ready` are both high. `st_ready` is high whenever the single output register is empty or is being drained in the same cycle. While `act_valid` is high and `act_ready` is low, the action fields do not change and no new store is accepted.

Top module: `gran_guard`

## Requirements
- R1: After reset every entry uses the default mode (line mode when `DEF_PAGE` is 0), `act_valid` is low, and `promote` and `demote` are all zero.
- R2: A page-mode store whose target tag is LAST (tag code 2) while `last_persisted` is low yields COPY_PAGE (action bit 1).
- R3: A page-mode store with tag LAST while `last_persisted` is high yields PROCEED (action bit 0) with `act_retag` high. `act_retag` is low for every other store.
- R4: A line-mode store whose target tag is PENULT (tag code 3) while `last_persisted` is low yields BUFFER_LINE (action bit 2) if `slot_free` is high, and STALL (action bit 3) if it is low.
- R5: Every other combination of mode, tag (0 none, 1 active), `last_persisted` and `slot_free` yields PROCEED. `slot_free` has no effect on page-mode stores.
- R6: An accepted store produces its action on the next cycle, with `act_valid` high, exactly one action bit set, and `act_entry`/`act_page` naming the target entry and the mode used. While `act_ready` is low, the outputs are held and `st_ready` is low.
- R7: On `epoch_end`, a line-mode entry whose count is strictly greater than `thr_hi` switches to page mode. Its `promote` bit is high for exactly the following cycle.
- R8: On `epoch_end`, a page-mode entry whose count is strictly less than `thr_lo` switches to line mode. Its `demote` bit is high for exactly the following cycle.
- R9: Every other entry keeps its mode across `epoch_end`. Counts and thresholds have no effect outside an `epoch_end` cycle.
- R10: A store accepted in the same cycle as `epoch_end` is judged with the mode that held before the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| epoch_end | input | 1 | One-cycle strobe that closes an epoch |
| store_cnt | input | NREG*CW | Per-entry store counts for the closing epoch; entry i is at bits [i*CW +: CW] |
| thr_hi | input | CW | Promotion threshold |
| thr_lo | input | CW | Demotion threshold, expected below thr_hi |
| last_persisted | input | 1 | The previous epoch is fully persisted |
| slot_free | input | 1 | A temporary line buffer slot is available |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high with st_valid |
| st_entry | input | IW | Target entry index |
| st_tag | input | 2 | Epoch of the target's newest version: 0 none, 1 active, 2 last, 3 penult |
| act_valid | output | 1 | Action valid |
| act_ready | input | 1 | Consumer takes the action |
| act | output | 4 | One-hot action: bit0 proceed, bit1 copy page, bit2 buffer line, bit3 stall |
| act_page | output | 1 | Mode used for this store (1 = page) |
| act_retag | output | 1 | The page entry is to be retagged to the active epoch |
| act_entry | output | IW | Entry the action refers to |
| promote | output | NREG | One-cycle line-to-page switch flags |
| demote | output | NREG | One-cycle page-to-line switch flags |

## Verification
A corrupted mode bit does not raise an alarm on its own. It surfaces only on the next store to that entry, as a wrong `act_page` and possibly a wrong action one cycle after acceptance, or at the next boundary as a missing or spurious `promote`/`demote` pulse. For that reason, the bench follows every boundary with one probe store per entry, so that any mode error shows within a few cycles. Decision errors appear on the first store that hits the affected combination, which is why the full cross product of mode, tag, persistence and slot availability is swept.

// File: rtl/gg_pkg.sv
package gg_pkg;
  typedef enum logic [1:0] {
    TAG_NONE   = 2'd0,
    TAG_ACTIVE = 2'd1,
    TAG_LAST   = 2'd2,
    TAG_PENULT = 2'd3
  } ver_tag_e;

  localparam int ACT_W      = 4;
  localparam int A_PROCEED  = 0;
  localparam int A_COPY     = 1;
  localparam int A_BUFFER   = 2;
  localparam int A_STALL    = 3;

  typedef logic [ACT_W-1:0] act_t;
endpackage

// File: rtl/gg_mode_table.sv
module gg_mode_table #(
  parameter int NREG     = 16,
  parameter int CW       = 8,
  parameter bit DEF_PAGE = 1'b0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch_end,
  input  logic [NREG*CW-1:0] cnt_flat,
  input  logic [CW-1:0]    thr_hi,
  input  logic [CW-1:0]    thr_lo,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_page,
  output logic [NREG-1:0]  promote,
  output logic [NREG-1:0]  demote
);
  logic [NREG-1:0] mode_q;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic [CW-1:0] cnt;
    logic          up, dn;
    assign cnt = cnt_flat[i*CW +: CW];
    assign up  = !mode_q[i] && (cnt > thr_hi);
    assign dn  =  mode_q[i] && (cnt < thr_lo);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[i]  <= DEF_PAGE;
        promote[i] <= 1'b0;
        demote[i]  <= 1'b0;
      end else begin
        promote[i] <= epoch_end && up;
        demote[i]  <= epoch_end && dn;
        if (epoch_end && (up || dn)) mode_q[i] <= up;
      end
    end
  end

  assign rd_page = mode_q[rd_idx];
endmodule

// File: rtl/gg_order_rules.sv
module gg_order_rules
  import gg_pkg::*;
(
  input  logic     page,
  input  ver_tag_e tag,
  input  logic     last_persisted,
  input  logic     slot_free,
  output act_t     act,
  output logic     retag
);
  always_comb begin
    act   = '0;
    retag = 1'b0;
    act[A_PROCEED] = 1'b1;
    if (page) begin
      if (tag == TAG_LAST) begin
        if (!last_persisted) begin
          act = '0;
          act[A_COPY] = 1'b1;
        end else begin
          retag = 1'b1;
        end
      end
    end else if (tag == TAG_PENULT && !last_persisted) begin
      act = '0;
      if (slot_free) act[A_BUFFER] = 1'b1;
      else           act[A_STALL]  = 1'b1;
    end
  end
endmodule

// File: rtl/gg_out_stage.sv
module gg_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/gran_guard.sv
module gran_guard
  import gg_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int CW       = 8,
  parameter bit DEF_PAGE = 1'b0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               epoch_end,
  input  logic [NREG*CW-1:0] store_cnt,
  input  logic [CW-1:0]      thr_hi,
  input  logic [CW-1:0]      thr_lo,
  input  logic               last_persisted,
  input  logic               slot_free,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [IW-1:0]      st_entry,
  input  logic [1:0]         st_tag,
  output logic               act_valid,
  input  logic               act_ready,
  output logic [ACT_W-1:0]   act,
  output logic               act_page,
  output logic               act_retag,
  output logic [IW-1:0]      act_entry,
  output logic [NREG-1:0]    promote,
  output logic [NREG-1:0]    demote
);
  localparam int DW = IW + ACT_W + 2;

  logic     cur_page;
  act_t     dec_act;
  logic     dec_retag;
  logic [DW-1:0] out_bus;

  gg_mode_table #(.NREG(NREG), .CW(CW), .DEF_PAGE(DEF_PAGE)) u_modes (
    .clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .cnt_flat(store_cnt),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .rd_idx(st_entry), .rd_page(cur_page),
    .promote(promote), .demote(demote)
  );

  gg_order_rules u_rules (
    .page(cur_page), .tag(ver_tag_e'(st_tag)), .last_persisted(last_persisted),
    .slot_free(slot_free), .act(dec_act), .retag(dec_retag)
  );

  gg_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_valid), .in_ready(st_ready),
    .in_data({st_entry, cur_page, dec_retag, dec_act}),
    .out_valid(act_valid), .out_ready(act_ready), .out_data(out_bus)
  );

  assign act       = out_bus[ACT_W-1:0];
  assign act_retag = out_bus[ACT_W];
  assign act_page  = out_bus[ACT_W+1];
  assign act_entry = out_bus[DW-1 -: IW];
endmodule

// File: rtl/gran_guard_chk.sv
module gran_guard_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            epoch_end,
  input logic            st_valid,
  input logic            st_ready,
  input logic            act_valid,
  input logic            act_ready,
  input logic [3:0]      act,
  input logic            act_page,
  input logic            act_retag,
  input logic [NREG-1:0] promote,
  input logic [NREG-1:0] demote
);
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> ($countones(act) == 1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |=> (act_valid && $stable(act) && $stable(act_page)));

  a_r6_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |-> !st_ready);

  a_r2_copy_page_only: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act[1]) |-> act_page);

  a_r4_line_only: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (act[2] || act[3])) |-> !act_page);

  a_r3_retag: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_retag) |-> (act[0] && act_page));

  a_r7_promote_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|promote) |-> $past(epoch_end));

  a_r8_demote_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|demote) |-> $past(epoch_end));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (promote & demote) == '0);
endmodule

bind gran_guard gran_guard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .st_valid(st_valid),
  .st_ready(st_ready), .act_valid(act_valid), .act_ready(act_ready), .act(act),
  .act_page(act_page), .act_retag(act_retag), .promote(promote), .demote(demote)
);

// File: tb/sim_gran_guard.sv
`timescale 1ns/1ps
module sim_gran_guard;
  localparam int NREG = 4;
  localparam int CW   = 4;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epoch_end = 1'b0;
  logic [NREG*CW-1:0] store_cnt = '0;
  logic [CW-1:0] thr_hi = 4'd9, thr_lo = 4'd4;
  logic last_persisted = 1'b0, slot_free = 1'b0;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [IW-1:0] st_entry = '0;
  logic [1:0] st_tag = '0;
  logic act_valid;
  logic act_ready = 1'b1;
  logic [3:0] act;
  logic act_page, act_retag;
  logic [IW-1:0] act_entry;
  logic [NREG-1:0] promote, demote;

  int checks = 0;
  int errors = 0;
  logic [NREG-1:0] mdl_mode = '0;

  always #4 clk = ~clk;

  gran_guard #(.NREG(NREG), .CW(CW), .DEF_PAGE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .store_cnt(store_cnt),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .last_persisted(last_persisted),
    .slot_free(slot_free), .st_valid(st_valid), .st_ready(st_ready),
    .st_entry(st_entry), .st_tag(st_tag), .act_valid(act_valid),
    .act_ready(act_ready), .act(act), .act_page(act_page), .act_retag(act_retag),
    .act_entry(act_entry), .promote(promote), .demote(demote)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] expect_act(input logic page, input logic [1:0] tag,
                                            input logic lp, input logic sf);
    // {retag, act[3:0]}
    if (page && tag == 2'd2 && !lp) return 5'b0_0010;
    if (page && tag == 2'd2 &&  lp) return 5'b1_0001;
    if (!page && tag == 2'd3 && !lp) return sf ? 5'b0_0100 : 5'b0_1000;
    return 5'b0_0001;
  endfunction

  task automatic do_store(input string req, input int e, input logic [1:0] tag,
                          input logic lp, input logic sf);
    @(negedge clk);
    st_valid = 1'b1; st_entry = IW'(e); st_tag = tag;
    last_persisted = lp; slot_free = sf;
    @(negedge clk);
    st_valid = 1'b0;
    check(req, {act_valid, act_entry, act_page, act_retag, act},
          {1'b1, IW'(e), mdl_mode[e], expect_act(mdl_mode[e], tag, lp, sf)});
  endtask

  task automatic do_epoch(input string req, input logic [NREG*CW-1:0] cnts,
                          input logic [CW-1:0] hi, input logic [CW-1:0] lo);
    logic [NREG-1:0] up, dn;
    up = '0; dn = '0;
    for (int i = 0; i < NREG; i++) begin
      if (!mdl_mode[i] && cnts[i*CW +: CW] > hi) up[i] = 1'b1;
      if ( mdl_mode[i] && cnts[i*CW +: CW] < lo) dn[i] = 1'b1;
    end
    @(negedge clk);
    store_cnt = cnts; thr_hi = hi; thr_lo = lo; epoch_end = 1'b1;
    @(negedge clk);
    epoch_end = 1'b0;
    check({req, " R7 promote"}, promote, up);
    check({req, " R8 demote"}, demote, dn);
    mdl_mode = (mdl_mode | up) & ~dn;
    @(negedge clk);
    check({req, " R7/R8 pulse width"}, {promote, demote}, '0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs after reset", {act_valid, promote, demote}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {act_valid, st_ready}, 2'b01);
    for (int e = 0; e < NREG; e++) do_store("R1 default line mode", e, 2'd0, 1'b0, 1'b0);

    // R7: entry 0 promoted, others stay line
    do_epoch("R7 first boundary", {4'd5, 4'd5, 4'd5, 4'd15}, 4'd9, 4'd4);

    // R2-R5: full cross product on page entry 0 and line entry 1
    for (int e = 0; e < 2; e++)
      for (int t = 0; t < 4; t++)
        for (int lp = 0; lp < 2; lp++)
          for (int sf = 0; sf < 2; sf++)
            do_store("R2/R3/R4/R5 decision sweep", e, 2'(t), 1'(lp), 1'(sf));

    // R9: counts without epoch_end change nothing
    @(negedge clk);
    store_cnt = '1; thr_hi = '0; thr_lo = '1;
    repeat (2) @(negedge clk);
    check("R9 no boundary no pulse", {promote, demote}, '0);
    for (int e = 0; e < NREG; e++) do_store("R9 modes untouched", e, 2'd0, 1'b1, 1'b1);

    // R7/R8/R9: arithmetic sweep of counts and thresholds
    for (int tr = 0; tr < 64; tr++) begin
      logic [NREG*CW-1:0] c;
      for (int i = 0; i < NREG; i++) c[i*CW +: CW] = CW'((tr*5 + i*7 + tr/3) % 16);
      do_epoch("R9 boundary sweep", c, CW'(6 + tr % 4), CW'(2 + tr % 3));
      for (int e = 0; e < NREG; e++) do_store("R9 mode probe", e, 2'(tr % 4), 1'(tr % 2), 1'b0);
    end

    // R10: store together with a boundary uses the old mode
    begin
      logic [NREG*CW-1:0] c;
      logic old;
      old = mdl_mode[2];
      c = '0;
      for (int i = 0; i < NREG; i++) c[i*CW +: CW] = old ? 4'd0 : 4'd15;
      @(negedge clk);
      store_cnt = c; thr_hi = 4'd9; thr_lo = 4'd4; epoch_end = 1'b1;
      st_valid = 1'b1; st_entry = 2'd2; st_tag = 2'd0;
      @(negedge clk);
      epoch_end = 1'b0; st_valid = 1'b0;
      check("R10 same-cycle store mode", {act_valid, act_page}, {1'b1, old});
      check("R10 entry switched", old ? demote[2] : promote[2], 1'b1);
      mdl_mode[2] = ~old;
      for (int i = 0; i < NREG; i++)
        if (i != 2 && mdl_mode[i] == old) mdl_mode[i] = ~old;
      do_store("R10 new mode after boundary", 2, 2'd0, 1'b0, 1'b0);
    end

    // R6: back-pressure
    @(negedge clk);
    act_ready = 1'b0;
    st_valid = 1'b1; st_entry = 2'd1; st_tag = 2'd3; last_persisted = 1'b0; slot_free = 1'b0;
    @(negedge clk);
    st_entry = 2'd3; st_tag = 2'd0; last_persisted = 1'b1;
    check("R6 stalled st_ready", {act_valid, st_ready}, 2'b10);
    check("R6 first held", {act_entry, act_page, act_retag, act},
          {2'd1, mdl_mode[1], expect_act(mdl_mode[1], 2'd3, 1'b0, 1'b0)});
    @(negedge clk);
    check("R6 still held", {act_valid, act_entry, act_page, act_retag, act},
          {1'b1, 2'd1, mdl_mode[1], expect_act(mdl_mode[1], 2'd3, 1'b0, 1'b0)});
    act_ready = 1'b1;
    @(negedge clk);
    st_valid = 1'b0;
    check("R6 second after release", {act_valid, act_entry, act_page, act_retag, act},
          {1'b1, 2'd3, mdl_mode[3], expect_act(mdl_mode[3], 2'd0, 1'b1, 1'b0)});
    @(negedge clk);
    check("R6 drained", act_valid, 1'b0);

    finish_run();
  end
endmodule